// File: doc/BRIEF.md
# Toggle-Event Data Word Synchronizer

This block carries a multi-bit data word from a free-running source clock domain into a fixed destination clock domain. While its enable is high, the source side counts its own clock cycles in groups of eight. At the end of each group it captures the current input word into a holding register and inverts a one-bit event level. The held word then stays put for the next eight source cycles.

The destination side passes the event level through a two-stage synchronizer and keeps one more registered copy of it. Any disagreement between the copy and the synchronizer output is an event, in either direction. On that event the destination copies the held word into its output register and raises a valid strobe for one destination cycle. The source clock may run anywhere from one thousandth of the destination rate up to twice it. Eight source cycles at the fastest ratio last four destination cycles, which is longer than the three-cycle detection latency, so events never merge.

Top module: `evt_bundle_xfer`

## Requirements
- R1: `rst_n` low clears the group counter, the event level, the holding register, `dst_word` (to 0) and `dst_valid` at once, with no clock. Each domain leaves reset on the second rising edge of its own clock after `rst_n` rises.
- R2: While `src_en` is high, one event occurs on every eighth enabled source edge. The first event falls on the eighth enabled source edge after the source domain leaves reset.
- R3: On an event source edge, the holding register takes the value `src_word` has at that edge and the event level inverts. Both keep these values until the next event.
- R4: While `src_en` is low, no event occurs, and the counter, the event level and the holding register keep their values. Counting resumes from where it stopped when `src_en` returns high.
- R5: The event level reaches the destination through two destination flops. A rising change and a falling change each produce exactly one event.
- R6: For each event, `dst_word` loads the held word and `dst_valid` is high for exactly one destination cycle. `dst_word` changes only in a cycle where `dst_valid` is high.
- R7: For any source frequency from 1/1000 to 2 times the destination frequency, every captured word appears on `dst_word` exactly once and in capture order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| dst_clk | input | 1 | Destination domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, shared by both domains |
| src_en | input | 1 | Source enable; groups are counted only while high |
| src_word | input | W | Source data word, sampled on event edges |
| dst_word | output | W | Last delivered word |
| dst_valid | output | 1 | One-cycle strobe marking a new word on dst_word |

## Verification
The word path is driven at three clock ratios: a source twice as fast as the destination, equal rates, and a source a thousand times slower. The source word changes on every source cycle. This shows whether the sampling edge, the merging of events at the fast ratio, and the sampling of a stale or moving held word are right. Each run includes a pause in the enable in the middle of a group, which separates a counter that resumes from one that restarts or keeps running. A directed case holds the enable low for a long time and then splits one group across a pause. This tells whether a disabled source can still raise events and where the first event lands. Another directed case pulls reset during traffic to confirm that the outputs clear asynchronously.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;
  localparam int unsigned DEF_WORD_W   = 16;
  localparam int unsigned DEF_GROUP    = 8;
  localparam int unsigned DEF_SYNC_LEN = 2;

  function automatic int unsigned cnt_width(input int unsigned group);
    return (group < 2) ? 1 : $clog2(group);
  endfunction
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/evt_src_stage.sv
module evt_src_stage
  import evt_xfer_pkg::*;
#(
  parameter int unsigned W     = DEF_WORD_W,
  parameter int unsigned GROUP = DEF_GROUP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] word_in,
  output logic         flag,
  output logic [W-1:0] hold
);
  localparam int unsigned CW = cnt_width(GROUP);
  localparam logic [CW-1:0] LAST = CW'(GROUP - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic [W-1:0]  hold_q, hold_d;
  logic          fire;

  always_comb begin
    fire   = en && (cnt_q == LAST);
    cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    flag_d = ~flag_q;
    hold_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (en)   cnt_q  <= cnt_d;
      if (fire) flag_q <= flag_d;
      if (fire) hold_q <= hold_d;
    end
  end

  assign flag = flag_q;
  assign hold = hold_q;
endmodule

// File: rtl/evt_flag_sync.sv
module evt_flag_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[0] <= 1'b0;
          else        st_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[i] <= 1'b0;
          else        st_q[i] <= st_q[i-1];
        end
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/evt_dst_stage.sv
module evt_dst_stage
  import evt_xfer_pkg::*;
#(
  parameter int unsigned W = DEF_WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_s,
  input  logic [W-1:0] hold,
  output logic [W-1:0] word_out,
  output logic         valid
);
  logic         seen_q;
  logic         valid_q, valid_d;
  logic [W-1:0] word_q;
  logic         evt;

  always_comb begin
    evt     = flag_s ^ seen_q;
    valid_d = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      seen_q  <= flag_s;
      valid_q <= valid_d;
      if (evt) word_q <= hold;
    end
  end

  assign word_out = word_q;
  assign valid    = valid_q;
endmodule

// File: rtl/evt_bundle_xfer.sv
module evt_bundle_xfer
  import evt_xfer_pkg::*;
#(
  parameter int unsigned W        = DEF_WORD_W,
  parameter int unsigned GROUP    = DEF_GROUP,
  parameter int unsigned SYNC_LEN = DEF_SYNC_LEN
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic         src_en,
  input  logic [W-1:0] src_word,
  output logic [W-1:0] dst_word,
  output logic         dst_valid
);
  logic         src_rst_n;
  logic         dst_rst_n;
  logic         src_flag;
  logic [W-1:0] src_hold;
  logic         dst_flag_s;

  evt_rst_sync #(.STAGES(2)) u_src_rst (
    .clk(src_clk), .rst_n_in(rst_n), .rst_n_out(src_rst_n)
  );

  evt_rst_sync #(.STAGES(2)) u_dst_rst (
    .clk(dst_clk), .rst_n_in(rst_n), .rst_n_out(dst_rst_n)
  );

  evt_src_stage #(.W(W), .GROUP(GROUP)) u_src (
    .clk(src_clk), .rst_n(src_rst_n), .en(src_en), .word_in(src_word),
    .flag(src_flag), .hold(src_hold)
  );

  evt_flag_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(src_flag), .q(dst_flag_s)
  );

  evt_dst_stage #(.W(W)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_n), .flag_s(dst_flag_s), .hold(src_hold),
    .word_out(dst_word), .valid(dst_valid)
  );
endmodule

// File: rtl/evt_bundle_xfer_chk.sv
module evt_bundle_xfer_chk #(
  parameter int unsigned W = 16
) (
  input logic         src_clk,
  input logic         dst_clk,
  input logic         src_rst_n,
  input logic         dst_rst_n,
  input logic         src_en,
  input logic         flag,
  input logic [W-1:0] hold,
  input logic [W-1:0] dst_word,
  input logic         dst_valid
);
  // R4
  flag_idle_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_en |=> $stable(flag));

  // R3
  hold_event_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $stable(flag) |-> $stable(hold));

  // R6
  single_valid_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |=> !dst_valid);

  // R6
  out_stable_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !dst_valid |-> $stable(dst_word));
endmodule

bind evt_bundle_xfer evt_bundle_xfer_chk #(.W(W)) u_chk (
  .src_clk(src_clk), .dst_clk(dst_clk), .src_rst_n(src_rst_n),
  .dst_rst_n(dst_rst_n), .src_en(src_en), .flag(src_flag), .hold(src_hold),
  .dst_word(dst_word), .dst_valid(dst_valid)
);

// File: tb/evt_bundle_xfer_test.sv
module evt_bundle_xfer_test;
  localparam int unsigned W = 16;

  typedef struct packed {
    int unsigned half;
    int unsigned nev;
    int unsigned gap;
  } phase_t;

  // source half periods: 5 ns = 2x fast, 10 ns = 1:1, 10000 ns = 1/1000
  localparam phase_t PHASES [3] = '{
    '{half: 5,     nev: 6, gap: 4},
    '{half: 10,    nev: 6, gap: 3},
    '{half: 10000, nev: 3, gap: 3}
  };

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         rst_n   = 1'b0;
  logic         src_en  = 1'b0;
  logic [W-1:0] src_word = '0;
  logic [W-1:0] dst_word;
  logic         dst_valid;

  int unsigned src_half = 5;
  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned recv = 0;
  int unsigned pushed = 0;
  int unsigned cyc = 0;
  logic [W-1:0] seq = '0;
  logic [W-1:0] exp_q [$];
  int unsigned m_cnt = 0;
  int unsigned m_seen = 0;
  logic prev_v = 1'b0;

  evt_bundle_xfer #(.W(W)) uut (
    .src_clk(src_clk), .dst_clk(dst_clk), .rst_n(rst_n), .src_en(src_en),
    .src_word(src_word), .dst_word(dst_word), .dst_valid(dst_valid)
  );

  always #10 dst_clk = ~dst_clk;
  always #(src_half) src_clk = ~src_clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // requirement model: counting starts two source edges after release (R1, R2)
  always @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_seen = 0;
      exp_q.delete();
    end else if (m_seen < 2) begin
      m_seen++;
    end else if (src_en) begin
      if (m_cnt == 7) begin
        exp_q.push_back(src_word);
        pushed++;
      end
      m_cnt = (m_cnt + 1) % 8;
    end
  end

  // destination monitor (R5, R6, R7)
  always @(negedge dst_clk) begin
    if (rst_n) begin
      if (dst_valid) begin
        check(!prev_v, "R6", "valid longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected delivery", dst_word, -1);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(dst_word == e, "R7", "delivered word", dst_word, e);
        end
        recv++;
      end
      prev_v = dst_valid;
    end else begin
      prev_v = 1'b0;
    end
  end

  always @(posedge dst_clk) begin
    cyc++;
    if (cyc > 180000) begin
      check(1'b0, "R7", "watchdog expired", cyc, 180000);
      finish_run();
    end
  end

  task automatic start(input int unsigned half, input logic en0);
    rst_n = 1'b0;
    src_en = 1'b0;
    src_half = half;
    repeat (3) @(negedge dst_clk);
    #1;
    check(dst_valid == 1'b0, "R1", "valid in reset", dst_valid, 0);
    check(dst_word == '0, "R1", "word in reset", dst_word, 0);
    recv = 0;
    pushed = 0;
    @(negedge src_clk);
    seq = seq + 1'b1;
    src_word = seq;
    src_en = en0;
    #1 rst_n = 1'b1;
  endtask

  task automatic drive(input int unsigned n, input logic en);
    for (int i = 0; i < int'(n); i++) begin
      @(negedge src_clk);
      seq = seq + 1'b1;
      src_word = seq;
      src_en = en;
    end
  endtask

  task automatic drain();
    @(negedge src_clk);
    src_en = 1'b0;
    repeat (3) @(negedge src_clk);
    repeat (8) @(negedge dst_clk);
  endtask

  initial begin
    // ratio sweep (R2, R3, R4, R5, R7)
    for (int p = 0; p < 3; p++) begin
      phase_t ph;
      int unsigned total;
      ph = PHASES[p];
      total = ph.nev * 8 + ph.gap + 1;
      seq = W'(p * 4096);
      start(ph.half, 1'b1);
      for (int n = 0; n < int'(total); n++) begin
        @(negedge src_clk);
        seq = seq + 1'b1;
        src_word = seq;
        src_en = !(n >= 12 && n < 12 + int'(ph.gap));
      end
      drain();
      check(pushed == ph.nev, "R2", "events per enabled groups", pushed, ph.nev);
      check(recv == ph.nev, "R7", "deliveries", recv, ph.nev);
      check(exp_q.size() == 0, "R7", "undelivered words", exp_q.size(), 0);
    end

    // long disable: nothing moves (R4)
    start(5, 1'b0);
    drive(40, 1'b0);
    repeat (8) @(negedge dst_clk);
    check(recv == 0, "R4", "deliveries while disabled", recv, 0);
    check(dst_word == '0, "R4", "word while disabled", dst_word, 0);

    // group split by pause: one event on 8th enabled edge (R2, R4)
    drive(5, 1'b1);
    drive(20, 1'b0);
    drive(3, 1'b1);
    drain();
    check(pushed == 1, "R4", "events after resumed group", pushed, 1);
    check(recv == 1, "R2", "first event delivered", recv, 1);

    // asynchronous reset during traffic (R1)
    start(5, 1'b1);
    drive(30, 1'b1);
    @(negedge dst_clk);
    check(dst_word != '0, "R1", "traffic before reset", dst_word, 1);
    #3 rst_n = 1'b0;
    #1;
    check(dst_word == '0, "R1", "async clear of word", dst_word, 0);
    check(dst_valid == 1'b0, "R1", "async clear of valid", dst_valid, 0);
    src_en = 1'b0;
    repeat (4) @(negedge dst_clk);
    finish_run();
  end
endmodule